// File: doc/BRIEF.md
# Dual Clock Comparator

The block checks how fast one clock runs compared with another. A reference clock and a clock under test are each picked from a small set of source clocks by select inputs. Each chosen clock drives its own down counter in its own domain. The reference side first counts an early bound. It then counts an acceptance window. The test side counts its own seed down to zero. If the test counter expires inside the window, the measurement passes. If it expires before the early bound, or after the window closes, the block raises an error.

Software sets the early bound, the window length and the test seed through a small write/read register bus clocked by the system clock. It then sets a start bit. A pass sets a sticky done flag. In continuous mode, a pass starts the next measurement on its own. An error is sticky and stops all counting. No new measurement starts until software clears the error and starts again. Run requests cross into both counter domains through two-flop synchronizers. Counter progress and results cross back the same way. The pass/fail decision is made in the reference domain.

Top module: `dual_clk_cmp`

## Requirements
- R1: After reset, err_o and done_o are low and every register reads zero.
- R2: Register map, with 16-bit data. Address 1 holds the early bound, address 2 the window length and address 3 the test seed; each reads back what was written. Address 0 is control: bit0 written 1 starts a measurement and bit0 written 0 stops it; bit1 is continuous mode; bit0 reads the busy state. Address 4 is status: bit0 error, bit1 done, bit2 busy. Writing 1 to status bit0 or bit1 clears that flag.
- R3: When the test counter expires while the reference counter is inside its window, done_o rises and err_o stays low.
- R4: When the test counter expires before the reference counter has finished its early bound (test clock too fast), err_o rises and done_o stays low.
- R5: When the reference window runs out before the test counter expires (test clock too slow), err_o rises and done_o stays low.
- R6: err_o is sticky. After an error, busy drops and counting stops. err_o stays high until status bit0 is written with 1.
- R7: A start write is ignored while err_o is high.
- R8: In continuous mode, a pass restarts the measurement without software action. Busy stays high, and done_o rises again after being cleared.
- R9: Writes to the early bound, window and test seed registers are ignored while busy.
- R10: Writing control bit0 as 0 during a measurement ends it with neither error nor done, and busy drops.
- R11: ref_sel_i picks the source clock index used for the reference counter, and cut_sel_i picks the source clock index used for the test counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for registers and control |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | N_SRC | Candidate source clocks |
| ref_sel_i | input | SEL_W | Index of the reference clock |
| cut_sel_i | input | SEL_W | Index of the clock under test |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| err_o | output | 1 | Sticky out-of-tolerance flag |
| done_o | output | 1 | Sticky measurement-passed flag |

## Verification
The hardest situation to reach is the continuous-mode relaunch. After a pass, the control logic has to wait until both foreign domains have dropped their activity before it starts the next run. A stale pass must not be taken for a new one. The bench reaches this by setting continuous mode with a passing clock pair, clearing done after the first pass, and waiting for done to return while busy never drops. Fast, slow and in-window clock pairs come from source clocks with different periods. Each case is chosen with wide margins, so that the few cycles of synchronizer delay cannot change its outcome.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_EARLY = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIN = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEED = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} ctl_state_e;
  typedef enum logic [2:0] {P_IDLE, P_CNT, P_WIN, P_PASS, P_FAIL} ref_phase_e;
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcc_cut_cnt.sv
`timescale 1ns/1ps
module dcc_cut_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             cut_clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] seed_i,
  output logic             active_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic run_s;
  logic loaded_q, zero_q;
  logic [CNT_W-1:0] cnt_q;

  dcc_sync #(.W(1)) u_run_sync (
    .clk_i(cut_clk_i), .rst_ni(rst_ni), .d_i(run_i), .q_o(run_s)
  );

  always_ff @(posedge cut_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      zero_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (!run_s) begin
      loaded_q <= 1'b0;
      zero_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      cnt_q    <= seed_i;  // seed is quasi-static while busy
    end else if (cnt_q == '0) begin
      zero_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign active_o = loaded_q;
  assign zero_o   = zero_q;
endmodule

// File: rtl/dcc_ref_cnt.sv
`timescale 1ns/1ps
module dcc_ref_cnt
  import dcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cut_zero_i,
  input  logic [CNT_W-1:0] early_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             active_o,
  output logic             pass_o,
  output logic             fail_o
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic run_s, cz_s;
  ref_phase_e phase_q;
  logic [CNT_W-1:0] cnt_q, win_q;

  dcc_sync #(.W(2)) u_in_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni),
    .d_i({run_i, cut_zero_i}), .q_o({run_s, cz_s})
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
      win_q   <= '0;
    end else if (!run_s) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
      win_q   <= '0;
    end else begin
      unique case (phase_q)
        P_IDLE: begin
          cnt_q   <= early_i;
          win_q   <= win_i;
          phase_q <= P_CNT;
        end
        P_CNT: begin
          if (cz_s)            phase_q <= P_FAIL;  // test clock too fast
          else if (cnt_q == '0) phase_q <= P_WIN;
          else                 cnt_q   <= cnt_q - ONE;
        end
        P_WIN: begin
          if (cz_s)            phase_q <= P_PASS;
          else if (win_q == '0) phase_q <= P_FAIL;  // test clock too slow
          else                 win_q   <= win_q - ONE;
        end
        default: ;  // hold result until run drops
      endcase
    end
  end

  assign active_o = (phase_q != P_IDLE);
  assign pass_o   = (phase_q == P_PASS);
  assign fail_o   = (phase_q == P_FAIL);
endmodule

// File: rtl/dual_clk_cmp.sv
`timescale 1ns/1ps
module dual_clk_cmp
  import dcc_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int CNT_W = 16,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_clk_i,
  input  logic [SEL_W-1:0]  ref_sel_i,
  input  logic [SEL_W-1:0]  cut_sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              err_o,
  output logic              done_o
);
  logic ref_clk, cut_clk;
  assign ref_clk = src_clk_i[ref_sel_i];
  assign cut_clk = src_clk_i[cut_sel_i];

  ctl_state_e state_q;
  logic busy, run;
  logic cont_q, relaunch_q, err_q, done_q;
  logic [CNT_W-1:0] early_q, win_q, seed_q;
  logic ref_act, ref_pass, ref_fail, cut_act, cut_zero;
  logic ref_act_s, ref_pass_s, ref_fail_s, cut_act_s;
  logic wr_ctrl, wr_stat;

  assign busy    = (state_q != S_IDLE);
  assign run     = (state_q == S_RUN);
  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_stat = we_i && (addr_i == A_STAT);

  dcc_ref_cnt #(.CNT_W(CNT_W)) u_ref (
    .ref_clk_i(ref_clk), .rst_ni(rst_ni), .run_i(run), .cut_zero_i(cut_zero),
    .early_i(early_q), .win_i(win_q),
    .active_o(ref_act), .pass_o(ref_pass), .fail_o(ref_fail)
  );

  dcc_cut_cnt #(.CNT_W(CNT_W)) u_cut (
    .cut_clk_i(cut_clk), .rst_ni(rst_ni), .run_i(run), .seed_i(seed_q),
    .active_o(cut_act), .zero_o(cut_zero)
  );

  dcc_sync #(.W(4)) u_back_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({ref_act, ref_pass, ref_fail, cut_act}),
    .q_o({ref_act_s, ref_pass_s, ref_fail_s, cut_act_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cont_q     <= 1'b0;
      relaunch_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      early_q    <= '0;
      win_q      <= '0;
      seed_q     <= '0;
    end else begin
      if (wr_ctrl) cont_q <= wdata_i[1];
      if (we_i && !busy) begin
        if (addr_i == A_EARLY) early_q <= wdata_i;
        if (addr_i == A_WIN)   win_q   <= wdata_i;
        if (addr_i == A_SEED)  seed_q  <= wdata_i;
      end
      if (wr_stat && wdata_i[0]) err_q  <= 1'b0;
      if (wr_stat && wdata_i[1]) done_q <= 1'b0;

      unique case (state_q)
        S_IDLE: begin
          if (wr_ctrl && wdata_i[0] && !err_q) state_q <= S_RUN;
        end
        S_RUN: begin
          if (ref_fail_s) begin
            err_q      <= 1'b1;
            relaunch_q <= 1'b0;
            state_q    <= S_DRAIN;
          end else if (ref_pass_s) begin
            done_q     <= 1'b1;
            relaunch_q <= cont_q && !(wr_ctrl && !wdata_i[0]);
            state_q    <= S_DRAIN;
          end else if (wr_ctrl && !wdata_i[0]) begin
            relaunch_q <= 1'b0;
            state_q    <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          // both domains must be seen idle before any relaunch
          if (!ref_act_s && !cut_act_s) begin
            state_q    <= relaunch_q ? S_RUN : S_IDLE;
            relaunch_q <= 1'b0;
          end else if (wr_ctrl && !wdata_i[0]) begin
            relaunch_q <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  begin rdata_o[0] = busy; rdata_o[1] = cont_q; end
      A_EARLY: rdata_o = early_q;
      A_WIN:   rdata_o = win_q;
      A_SEED:  rdata_o = seed_q;
      A_STAT:  begin rdata_o[0] = err_q; rdata_o[1] = done_q; rdata_o[2] = busy; end
      default: rdata_o = '0;
    endcase
  end

  assign err_o  = err_q;
  assign done_o = done_q;
endmodule

// File: rtl/dcc_checker.sv
`timescale 1ns/1ps
module dcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             err_o,
  input logic             done_o,
  input logic             busy,
  input logic [CNT_W-1:0] early_q
);
  logic clr_err, clr_done;
  assign clr_err  = we_i && (addr_i == 3'd4) && wdata_i[0];
  assign clr_done = we_i && (addr_i == 3'd4) && wdata_i[1];

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_err) |=> err_o);

  p_done_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_done) |=> done_o);

  p_no_start_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !busy) |=> !busy);

  p_seed_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(early_q));

  p_err_from_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(busy));

  p_done_from_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$rose(err_o));
endmodule

bind dual_clk_cmp dcc_checker #(.CNT_W(CNT_W)) u_dcc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .err_o(err_o), .done_o(done_o),
  .busy(busy), .early_q(early_q)
);

// File: tb/dual_clk_cmp_bench.sv
`timescale 1ns/1ps
module dual_clk_cmp_bench;
  localparam int N_SRC = 4;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [1:0]  rs;
    logic [1:0]  cs;
    logic [15:0] early;
    logic [15:0] win;
    logic [15:0] seed;
  } vec_t;

  // source periods in ns: 10, 10, 20, 5
  localparam vec_t VECS [6] = '{
    '{2'd0, 2'd1, 16'd90,  16'd20, 16'd100},
    '{2'd0, 2'd3, 16'd90,  16'd20, 16'd100},
    '{2'd0, 2'd2, 16'd90,  16'd20, 16'd100},
    '{2'd2, 2'd3, 16'd20,  16'd10, 16'd100},
    '{2'd3, 2'd0, 16'd180, 16'd40, 16'd100},
    '{2'd1, 2'd0, 16'd50,  16'd4,  16'd100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] src_clk = '0;
  logic [1:0] ref_sel = '0, cut_sel = '0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic err, done;

  int total = 0, bad = 0, cycles = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;
  always #5 src_clk[0] = ~src_clk[0];
  initial begin #1.3; forever #5 src_clk[1] = ~src_clk[1]; end
  always #10 src_clk[2] = ~src_clk[2];
  always #2.5 src_clk[3] = ~src_clk[3];

  dual_clk_cmp #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_dual_clk_cmp (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk),
    .ref_sel_i(ref_sel), .cut_sel_i(cut_sel),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .done_o(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !finished) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_flag(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (err || done) break;
    end
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd4, s);
      if (!s[2]) break;
    end
  endtask

  function automatic int per(input logic [1:0] i);
    case (i)
      2'd2: return 20;
      2'd3: return 5;
      default: return 10;
    endcase
  endfunction

  function automatic logic exp_pass(input vec_t v);
    int tc, lo, hi;
    tc = (int'(v.seed) + 1) * per(v.cs);
    lo = (int'(v.early) + 1) * per(v.rs);
    hi = (int'(v.early) + int'(v.win) + 2) * per(v.rs);
    return (tc > lo) && (tc < hi);
  endfunction

  task automatic load(input vec_t v);
    ref_sel = v.rs; cut_sel = v.cs;
    wr(3'd1, v.early);
    wr(3'd2, v.win);
    wr(3'd3, v.seed);
  endtask

  initial begin
    logic [15:0] r;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(!err && !done, "R1 flags", {err, done}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), r);
      check(r == 0, "R1 reg zero", r, 0);
    end

    // R2: register readback
    wr(3'd1, 16'h1234); rd(3'd1, r); check(r == 16'h1234, "R2 early", r, 16'h1234);
    wr(3'd2, 16'h0abc); rd(3'd2, r); check(r == 16'h0abc, "R2 win", r, 16'h0abc);
    wr(3'd3, 16'h7f01); rd(3'd3, r); check(r == 16'h7f01, "R2 seed", r, 16'h7f01);
    wr(3'd0, 16'h0002); rd(3'd0, r); check(r == 16'h0002, "R2 ctrl cont", r, 2);
    wr(3'd0, 16'h0000);

    // R3/R4/R5/R11: table of clock pairs
    foreach (VECS[k]) begin
      load(VECS[k]);
      e = exp_pass(VECS[k]);
      wr(3'd0, 16'h0001);
      wait_flag(20000);
      check(done == e && err == !e, e ? "R3 pass R11" : "R4/R5 fail R11", {done, err}, {e, !e});
      wait_idle();
      wr(3'd4, 16'h0003);
      rd(3'd4, r);
      check(r == 0, "R2 status clear", r, 0);
    end

    // R9 and R10: writes ignored while busy, then stop
    load('{2'd0, 2'd2, 16'd900, 16'd100, 16'd1000});
    wr(3'd0, 16'h0001);
    repeat (50) @(negedge clk);
    wr(3'd1, 16'd5);
    rd(3'd1, r);
    check(r == 16'd900, "R9 early held", r, 900);
    wr(3'd0, 16'h0000);
    repeat (100) @(negedge clk);
    rd(3'd4, r);
    check(r == 0, "R10 stopped clean", r, 0);

    // R6 and R7: sticky error halts, start ignored
    load(VECS[1]);
    wr(3'd0, 16'h0001);
    wait_flag(20000);
    check(err == 1'b1, "R4 early fail", err, 1);
    repeat (500) @(negedge clk);
    rd(3'd4, r);
    check(r == 16'h0001, "R6 sticky halted", r, 1);
    wr(3'd0, 16'h0001);
    repeat (300) @(negedge clk);
    rd(3'd4, r);
    check(r == 16'h0001, "R7 start ignored", r, 1);
    wr(3'd4, 16'h0001);
    rd(3'd4, r);
    check(r == 0, "R6 cleared", r, 0);

    // R8: continuous relaunch
    load(VECS[0]);
    wr(3'd0, 16'h0003);
    wait_flag(20000);
    check(done == 1'b1, "R8 first pass", done, 1);
    wr(3'd4, 16'h0002);
    rd(3'd4, r);
    check(r[2] == 1'b1, "R8 still busy", r, 4);
    check(r[1] == 1'b0, "R8 done cleared", r, 4);
    wait_flag(20000);
    check(done == 1'b1 && !err, "R8 second pass", {done, err}, 2);
    rd(3'd4, r);
    check(r[2] == 1'b1, "R8 busy after relaunch", r, 6);
    wr(3'd0, 16'h0000);
    wait_idle();
    wr(3'd4, 16'h0003);
    rd(3'd4, r);
    check(r == 0, "R10 cont stopped", r, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule